// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This controller sits between 21 maskable request lines and a processor core and decides which request the core services next. Each source has an enable bit and a priority bit, and one global enable bit gates all of them. A request can win only when its pending line, its enable bit and the global enable are all set. High-level requests beat low-level ones, and within a level the lower source index wins. Source `n` vectors to `0x0003 + 8*n`. The reset entry at `0x0000` cannot be masked and is what the vector output shows whenever no request is raised.

The core accepts a raised request with a one-cycle acknowledge strobe and ends a service routine with a one-cycle return strobe. The controller keeps a two-entry stack of the levels in service. A low-level routine can be preempted once by a high-level request, and nothing preempts a high-level routine. On each acknowledge the controller pulses a one-hot per-source line, so that a source which clears its flag in hardware can do so. Pending lines are level-sensitive: a line still asserted after a return raises a new request.

Configuration uses a write port with write enable, address and data. Address 0 holds the enable mask, address 1 the priority mask (1 = high) and address 2 the global enable in data bit 0.

Top module: `irq_ctrl2`

## Requirements
- R1: After reset, `irq_o` is 0, `irq_id_o` is 0, `irq_vec_o` is 0x0000 and `src_ack_o` is 0. All enables, the global enable and all priority bits are 0, so asserted pending lines raise no request.
- R2: While `irq_o` is 1, `irq_vec_o` equals 0x0003 + 8 × `irq_id_o`.
- R3: A source is eligible only when its pending line, its enable bit and the global enable are all 1. A disabled source, or any source while the global enable is 0, never raises `irq_o`.
- R4: An eligible high-level source wins over any eligible low-level source, whatever their indices.
- R5: Among eligible sources of the same level, the lowest index wins.
- R6: While a low-level routine is in service, low-level requests are held off and an eligible high-level request is raised (preemption).
- R7: While a high-level routine is in service, `irq_o` stays 0.
- R8: A return pops one level. If a pending line is still asserted, it raises a new request in the second cycle after the return strobe.
- R9: An acknowledge while `irq_o` is 1 drives `src_ack_o` one-hot at bit `irq_id_o` for that cycle only. An acknowledge while `irq_o` is 0 is ignored and `src_ack_o` stays 0.
- R10: A return with nothing in service is ignored and leaves the level stack empty.
- R11: The outputs are registered. `irq_o`, `irq_id_o` and `irq_vec_o` follow a change on the pending lines one clock later. In the cycle after an accepted acknowledge, `irq_o` is 0 and `irq_id_o` and `irq_vec_o` read 0.
- R12: A write takes effect at the next edge: address 0 sets the enable mask, 1 the priority mask (1 = high), 2 the global enable from data bit 0. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 21 | Level-sensitive pending lines, bit n = source n |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration address |
| cfg_wdata_i | input | 21 | Configuration write data |
| vec_ack_i | input | 1 | Core acknowledges the raised request |
| reti_i | input | 1 | Core returns from a service routine |
| irq_o | output | 1 | Request to the core |
| irq_id_o | output | 5 | Index of the winning source |
| irq_vec_o | output | 16 | Vector address of the winner, 0x0000 when idle |
| src_ack_o | output | 21 | One-cycle one-hot acknowledge per source |

## Verification
The assertions check the following on every cycle:
- the vector mapping, and the idle output values;
- the one-hot acknowledge lines;
- the dropped request after an acknowledge;
- silence while the global enable is off or a high-level routine runs;
- the bound on stack depth;
- that a return on an empty stack does nothing.

The winner selection itself (level before index), preemption of a low-level routine, hold-off of low requests, and re-requests after a return come out only in the bench scenarios. There a behavioural model with a queue of levels is compared against the outputs on every clock.

// File: rtl/irq_ctrl2.sv
module irq_ctrl2 #(
  parameter int NSRC     = 21,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend_i,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [NSRC-1:0]  cfg_wdata_i,
  input  logic             vec_ack_i,
  input  logic             reti_i,
  output logic             irq_o,
  output logic [$clog2(NSRC)-1:0] irq_id_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [NSRC-1:0]  src_ack_o
);
  localparam int IDW = $clog2(NSRC);

  logic [NSRC-1:0] en_q, pri_q;
  logic            gie_q;
  logic [1:0]      depth_q;
  logic [1:0]      stk_q;
  logic            lvl_q;
  logic            win_v, win_hi;
  logic [IDW-1:0]  win_id;

  wire top_hi = (depth_q == 2'd2) ? stk_q[1] : (depth_q == 2'd1) ? stk_q[0] : 1'b0;
  wire busy   = depth_q != 2'd0;
  wire push   = vec_ack_i & irq_o;
  wire pop    = reti_i & ~push & busy;

  wire [NSRC-1:0] elig   = pend_i & en_q & {NSRC{gie_q}};
  wire [NSRC-1:0] hi_req = elig & pri_q & {NSRC{~top_hi}};
  wire [NSRC-1:0] lo_req = elig & ~pri_q & {NSRC{~busy}};

  always_comb begin
    win_v  = 1'b0;
    win_hi = 1'b0;
    win_id = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (lo_req[i]) begin win_v = 1'b1; win_id = IDW'(i); end
    for (int i = NSRC-1; i >= 0; i--)
      if (hi_req[i]) begin win_v = 1'b1; win_hi = 1'b1; win_id = IDW'(i); end
  end

  wire             raise = win_v & ~push;
  wire [VEC_W-1:0] vec_d = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(win_id);

  assign src_ack_o = {{(NSRC-1){1'b0}}, push} << irq_id_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      pri_q     <= '0;
      gie_q     <= 1'b0;
      depth_q   <= '0;
      stk_q     <= '0;
      lvl_q     <= 1'b0;
      irq_o     <= 1'b0;
      irq_id_o  <= '0;
      irq_vec_o <= '0;
    end else begin
      if (cfg_we_i)
        case (cfg_addr_i)
          2'd0:    en_q  <= cfg_wdata_i;
          2'd1:    pri_q <= cfg_wdata_i;
          2'd2:    gie_q <= cfg_wdata_i[0];
          default: ;
        endcase
      if (push) begin
        stk_q[depth_q[0]] <= lvl_q;
        depth_q           <= depth_q + 2'd1;
      end else if (pop) begin
        depth_q <= depth_q - 2'd1;
      end
      irq_o     <= raise;
      lvl_q     <= raise & win_hi;
      irq_id_o  <= raise ? win_id : '0;
      irq_vec_o <= raise ? vec_d : '0;
    end
  end
endmodule

// File: rtl/irq_ctrl2_chk.sv
module irq_ctrl2_chk #(
  parameter int NSRC     = 21,
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic [1:0]       depth,
  input logic             in_hi,
  input logic             vec_ack_i,
  input logic             reti_i,
  input logic             irq_o,
  input logic [$clog2(NSRC)-1:0] irq_id_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [NSRC-1:0]  src_ack_o
);
  p_vec_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> int'(irq_vec_o) == VEC_BASE + VEC_STEP * int'(irq_id_o));
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (irq_vec_o == '0 && irq_id_o == '0));
  p_gie_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |=> !irq_o);
  p_hi_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_hi |=> !irq_o);
  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack_o));
  p_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> src_ack_o == '0);
  p_drop_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack_i && irq_o) |=> !irq_o);
  p_depth_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= 2'd2);
  p_reti_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !vec_ack_i && depth == 2'd0) |=> depth == 2'd0);
endmodule

bind irq_ctrl2 irq_ctrl2_chk #(
  .NSRC(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .gie(gie_q), .depth(depth_q), .in_hi(top_hi),
  .vec_ack_i(vec_ack_i), .reti_i(reti_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
  .irq_vec_o(irq_vec_o), .src_ack_o(src_ack_o)
);

// File: tb/irq_ctrl2_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl2_tb_top;
  localparam int N = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0;
  logic          we = 1'b0;
  logic [1:0]    addr = '0;
  logic [N-1:0]  wdata = '0;
  logic          ack = 1'b0, reti = 1'b0;
  logic          irq;
  logic [4:0]    id;
  logic [15:0]   vec;
  logic [N-1:0]  sack;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl2 dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .vec_ack_i(ack), .reti_i(reti), .irq_o(irq),
    .irq_id_o(id), .irq_vec_o(vec), .src_ack_o(sack)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit [N-1:0] m_en, m_pr;
  bit         m_gie, m_irq, m_hi;
  int         m_id;
  int         stk[$];

  always @(posedge clk) begin
    bit nv, nh;
    int ni;
    int top;
    if (!rst_n) begin
      m_en = '0; m_pr = '0; m_gie = 0; m_irq = 0; m_hi = 0; m_id = 0;
      stk.delete();
    end else begin
      top = (stk.size() == 0) ? -1 : stk[stk.size()-1];
      nv = 0; nh = 0; ni = 0;
      for (int i = 0; i < N; i++)
        if (!nv && m_gie && pend[i] && m_en[i] && m_pr[i] && top != 1) begin
          nv = 1; nh = 1; ni = i;
        end
      for (int i = 0; i < N; i++)
        if (!nv && m_gie && pend[i] && m_en[i] && !m_pr[i] && stk.size() == 0) begin
          nv = 1; ni = i;
        end
      if (ack && m_irq) begin
        stk.push_back(m_hi ? 1 : 0);
        nv = 0;
      end else if (reti && stk.size() > 0) begin
        void'(stk.pop_back());
      end
      if (we) begin
        if (addr == 0) m_en = wdata;
        if (addr == 1) m_pr = wdata;
        if (addr == 2) m_gie = wdata[0];
      end
      m_irq = nv;
      m_hi  = nv && nh;
      m_id  = nv ? ni : 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 model irq", 32'(irq), 32'(m_irq));
    chk("R5 model id", 32'(id), 32'(m_id));
    chk("R2 model vec", 32'(vec), m_irq ? 32'(3 + 8 * m_id) : 32'h0);
    chk("R9 model src_ack", 32'(sack), (ack && m_irq) ? 32'(1) << m_id : 32'h0);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    we = 1; addr = a; wdata = d; tick(); we = 0;
  endtask

  task automatic do_ack(int exp_id, string req);
    ack = 1; #0.5;
    chk(req, 32'(sack), 32'(1) << exp_id);
    tick(); ack = 0;
    chk("R11 irq low after ack", 32'(irq), 0);
  endtask

  task automatic do_reti();
    reti = 1; tick(); reti = 0;
  endtask

  task automatic expect_irq(bit v, int i, string req);
    chk(req, 32'(irq), 32'(v));
    if (v) begin
      chk(req, 32'(id), 32'(i));
      chk("R2 vector", 32'(vec), 32'(3 + 8 * i));
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    pend = '1;
    tick(3);
    rst_n = 1;
    tick();
    chk("R1 reset irq", 32'(irq), 0);
    chk("R1 reset vec", 32'(vec), 0);
    chk("R1 reset id", 32'(id), 0);
    chk("R1 reset src_ack", 32'(sack), 0);
    tick(3);
    chk("R1 nothing enabled", 32'(irq), 0);

    wr(0, '1); tick(3);
    expect_irq(0, 0, "R3 global enable off");
    wr(2, 1); tick(2);
    expect_irq(1, 0, "R5 lowest index of all");
    pend = N'(1) << 7; tick(2);
    expect_irq(1, 7, "R2 source 7");
    pend = '0;
    chk("R11 unchanged before edge", 32'(irq), 1);
    tick();
    chk("R11 follows one clock later", 32'(irq), 0);
    pend = N'(1) << 9; tick();
    expect_irq(1, 9, "R11 rise one clock later");
    pend = (N'(1) << 5) | (N'(1) << 12); tick(2);
    expect_irq(1, 5, "R5 same level 5 vs 12");
    wr(0, ~(N'(1) << 5)); tick(2);
    expect_irq(1, 12, "R3 disabled source ignored");
    wr(0, '1);

    wr(1, (N'(1) << 15) | (N'(1) << 16));
    pend = (N'(1) << 2) | (N'(1) << 15); tick(3);
    expect_irq(1, 15, "R4 high beats low");

    pend = (N'(1) << 2) | (N'(1) << 4); tick(2);
    expect_irq(1, 2, "R5 low 2 vs 4");
    do_ack(2, "R9 ack pulse source 2");
    tick(3);
    expect_irq(0, 0, "R6 low held off in low service");
    pend = pend | (N'(1) << 15); tick();
    expect_irq(1, 15, "R6 high preempts low");
    do_ack(15, "R9 ack pulse source 15");
    pend = pend | (N'(1) << 16); tick(3);
    expect_irq(0, 0, "R7 nothing during high service");
    do_reti();
    chk("R8 no request in return cycle", 32'(irq), 0);
    tick();
    expect_irq(1, 15, "R8 re-request after return");
    do_ack(15, "R9 ack pulse again");
    pend = (N'(1) << 2) | (N'(1) << 4);
    do_reti(); tick(3);
    expect_irq(0, 0, "R6 back in low service");
    do_reti(); tick(2);
    expect_irq(1, 2, "R8 low re-request after last return");

    pend = '0; tick(2);
    ack = 1; #0.5;
    chk("R9 ack ignored when idle", 32'(sack), 0);
    tick(); ack = 0;
    do_reti(); do_reti(); do_reti();
    pend = N'(1) << 4; tick(2);
    expect_irq(1, 4, "R10 empty return ignored");
    do_ack(4, "R9 ack pulse source 4");
    tick(3);
    expect_irq(0, 0, "R10 one level in service");
    do_reti(); tick(2);
    expect_irq(1, 4, "R10 single pop empties stack");

    wr(3, '0); tick(2);
    expect_irq(1, 4, "R12 address 3 no effect");
    wr(0, '0); tick(2);
    expect_irq(0, 0, "R12 enable mask cleared");
    wr(0, '1); wr(2, 0); tick(2);
    expect_irq(0, 0, "R12 global enable cleared");

    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule